// File: doc/BRIEF.md
# Poison-Bit Integer Register File

This block is an integer register file for a core that hoists loads and their uses above the branches that guard them. Every register holds a 64-bit value and one extra poison bit. A speculative load that would have faulted does not trap. Instead it writes its destination with the poison bit set. Any ALU result written from a poisoned source is poisoned too, so the fault travels silently down the dependence chain.

At the point where the hoisted work is actually consumed, a single check operation names one register. If that register's poison bit is set, the block raises a recovery request, and the branch unit then redirects to recovery code. Whenever the poison bit is set, the stored value is forced to zero, so poisoned data never leaks as a real number.

Two combinational read ports return value and poison bit. One write port carries a write kind: plain move/load, speculative load, or ALU result. A combinational check port returns the recovery request. Register 0 is hard-wired to a clean zero. A read of the register being written in the same cycle sees the new contents.

Top module: `poison_regfile`

## Requirements
- R1: After synchronous reset, every register reads value 0 with a clear poison bit on both read ports.
- R2: A write of kind move/load (code 2'b00, and the reserved code 2'b11 behaves the same) stores the poison bit given on `wr_poison`, so a clean move into a poisoned register clears its poison bit.
- R3: A write of kind speculative load (code 2'b01) sets the destination poison bit exactly when `wr_fault` is high, ignoring `wr_poison`; no exception output exists and the fault has no other effect.
- R4: A write of kind ALU (code 2'b10) sets the destination poison bit to the OR of the poison bits stored, before this write, in the registers addressed by read ports A and B in that cycle.
- R5: Whenever a register is written with its poison bit set, its stored value is zero regardless of `wr_data`.
- R6: `chk_recover` is high, in the same cycle, exactly when `chk_en` is high and the register addressed by `chk_addr` has its poison bit set.
- R7: Poison passes through a chain of ALU writes, so one check at the end of the chain raises recovery for a fault at its start.
- R8: Register 0 always reads value 0 with a clear poison bit, writes to it are ignored, and a check of it never requests recovery.
- R9: A read or check of a register in the same cycle as a write to it returns the value and poison bit being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_addr | input | 6 | Read port A register index |
| ra_data | output | 64 | Read port A value |
| ra_poison | output | 1 | Read port A poison bit |
| rb_addr | input | 6 | Read port B register index |
| rb_data | output | 64 | Read port B value |
| rb_poison | output | 1 | Read port B poison bit |
| wr_en | input | 1 | Write enable |
| wr_kind | input | 2 | 00 move/load, 01 speculative load, 10 ALU, 11 as move |
| wr_addr | input | 6 | Write register index |
| wr_data | input | 64 | Write value |
| wr_poison | input | 1 | Poison bit for move/load writes |
| wr_fault | input | 1 | Speculative load fault flag |
| chk_en | input | 1 | Check operation valid |
| chk_addr | input | 6 | Register tested by the check |
| chk_recover | output | 1 | Request to branch to recovery code |

## Verification
On every cycle, the assertions check the following: register 0 stays clean, any poisoned read carries a zero value, the check agrees with read port A whenever both address the same register, and a faulting speculative load or any completed write lands in storage. Three behaviours are shown only by the bench's scenarios, against a reference model built from the requirements: poison inheritance through ALU chains, clearing by a clean move, and same-cycle bypass on both ports.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        WK_MOVE    = 2'b00,
        WK_SPEC_LD = 2'b01,
        WK_ALU     = 2'b10,
        WK_RSVD    = 2'b11
    } wr_kind_e;

    typedef struct packed {
        logic              poison;
        logic [DATA_W-1:0] value;
    } rf_entry_t;

    // A poisoned entry never carries a value.
    function automatic rf_entry_t scrub(input logic poison, input logic [DATA_W-1:0] value);
        rf_entry_t e;
        e.poison = poison;
        e.value  = poison ? '0 : value;
        return e;
    endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store
    import poison_rf_pkg::*;
#(
    parameter int NREG = 64,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  rf_entry_t       wentry,
    output rf_entry_t       regs [NREG]
);

    rf_entry_t mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we && waddr != '0) begin
            mem[waddr] <= wentry;
        end
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs[i] = mem[i];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> (mem[$past(waddr)] == $past(wentry))) else $error("write lost"); // R2

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import poison_rf_pkg::*;
#(
    parameter int NREG = 64,
    localparam int AW = $clog2(NREG)
) (
    input  rf_entry_t       regs [NREG],
    input  logic [AW-1:0]   addr,
    input  logic            wr_live,
    input  logic [AW-1:0]   waddr,
    input  rf_entry_t       wentry,
    output rf_entry_t       rdata
);

    always_comb begin
        if (addr == '0) begin
            rdata = '0;
        end else if (wr_live && waddr == addr) begin
            rdata = wentry;
        end else begin
            rdata = regs[addr];
        end
    end

endmodule

// File: rtl/rf_check.sv
module rf_check
    import poison_rf_pkg::*;
#(
    parameter int NREG = 64,
    localparam int AW = $clog2(NREG)
) (
    input  rf_entry_t       regs [NREG],
    input  logic            en,
    input  logic [AW-1:0]   addr,
    input  logic            wr_live,
    input  logic [AW-1:0]   waddr,
    input  rf_entry_t       wentry,
    output logic            recover
);

    rf_entry_t probe;

    rf_read_port #(.NREG(NREG)) u_probe (
        .regs    (regs),
        .addr    (addr),
        .wr_live (wr_live),
        .waddr   (waddr),
        .wentry  (wentry),
        .rdata   (probe)
    );

    assign recover = en && probe.poison;

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
    import poison_rf_pkg::*;
#(
    parameter int NREG = 64,
    localparam int AW = $clog2(NREG),
    localparam int NRD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     ra_addr,
    output logic [DATA_W-1:0] ra_data,
    output logic              ra_poison,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] rb_data,
    output logic              rb_poison,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_poison,
    input  logic              wr_fault,
    input  logic              chk_en,
    input  logic [AW-1:0]     chk_addr,
    output logic              chk_recover
);

    rf_entry_t regs [NREG];
    rf_entry_t wentry;
    rf_entry_t rd_ent  [NRD];
    logic [AW-1:0] rd_addr [NRD];
    logic wr_live;
    logic src_poison;
    logic new_poison;

    assign wr_live = wr_en && wr_addr != '0;
    assign rd_addr[0] = ra_addr;
    assign rd_addr[1] = rb_addr;

    // ALU inheritance uses stored bits only, so the bypass path stays acyclic.
    assign src_poison = regs[ra_addr].poison | regs[rb_addr].poison;

    always_comb begin
        unique case (wr_kind_e'(wr_kind))
            WK_SPEC_LD: new_poison = wr_fault;
            WK_ALU:     new_poison = src_poison;
            default:    new_poison = wr_poison;
        endcase
        wentry = scrub(new_poison, wr_data);
    end

    rf_store #(.NREG(NREG)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wentry (wentry),
        .regs   (regs)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_read_port #(.NREG(NREG)) u_port (
            .regs    (regs),
            .addr    (rd_addr[p]),
            .wr_live (wr_live),
            .waddr   (wr_addr),
            .wentry  (wentry),
            .rdata   (rd_ent[p])
        );

        AST_POISON_ZERO: assert property (@(posedge clk) disable iff (rst)
            rd_ent[p].poison |-> rd_ent[p].value == '0) else $error("poisoned value"); // R5
    end

    assign ra_data   = rd_ent[0].value;
    assign ra_poison = rd_ent[0].poison;
    assign rb_data   = rd_ent[1].value;
    assign rb_poison = rd_ent[1].poison;

    rf_check #(.NREG(NREG)) u_check (
        .regs    (regs),
        .en      (chk_en),
        .addr    (chk_addr),
        .wr_live (wr_live),
        .waddr   (wr_addr),
        .wentry  (wentry),
        .recover (chk_recover)
    );

    AST_R0_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (ra_addr == '0) |-> (ra_data == '0 && !ra_poison)) else $error("r0 dirty"); // R8

    AST_CHK_AGREES: assert property (@(posedge clk) disable iff (rst)
        (chk_en && chk_addr == ra_addr) |-> (chk_recover == ra_poison)) else $error("check mismatch"); // R6

    AST_FAULT_POISONS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_kind == 2'b01 && wr_fault)
        |=> regs[$past(wr_addr)].poison) else $error("fault not recorded"); // R3

endmodule

// File: tb/poison_regfile_bench.sv
module poison_regfile_bench;

    logic        clk = 0;
    logic        rst = 1;
    logic [5:0]  ra_addr = 0, rb_addr = 0, wr_addr = 0, chk_addr = 0;
    logic [63:0] ra_data, rb_data, wr_data = 0;
    logic        ra_poison, rb_poison, chk_recover;
    logic        wr_en = 0, wr_poison = 0, wr_fault = 0, chk_en = 0;
    logic [1:0]  wr_kind = 0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    poison_regfile u_poison_regfile (
        .clk(clk), .rst(rst),
        .ra_addr(ra_addr), .ra_data(ra_data), .ra_poison(ra_poison),
        .rb_addr(rb_addr), .rb_data(rb_data), .rb_poison(rb_poison),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_poison(wr_poison), .wr_fault(wr_fault),
        .chk_en(chk_en), .chk_addr(chk_addr), .chk_recover(chk_recover)
    );

    typedef struct {
        logic [63:0] a_data; logic a_p;
        logic [63:0] b_data; logic b_p;
        logic        rec;
        string       req;
    } exp_t;

    exp_t q[$];

    logic [63:0] m_val [64];
    logic        m_p   [64];

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 0;
            m_p[i]   = 0;
        end
    end

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic step(input logic we, input logic [1:0] kind, input logic [5:0] wa,
                        input logic [63:0] wd, input logic wp, input logic wf,
                        input logic [5:0] a, input logic [5:0] b,
                        input logic ce, input logic [5:0] ca, input string req);
        exp_t e;
        logic np;
        logic [63:0] nv;
        logic live;
        @(posedge clk); #1;
        wr_en = we; wr_kind = kind; wr_addr = wa; wr_data = wd;
        wr_poison = wp; wr_fault = wf; ra_addr = a; rb_addr = b;
        chk_en = ce; chk_addr = ca;
        case (kind)
            2'b01:   np = wf;
            2'b10:   np = m_p[a] | m_p[b];
            default: np = wp;
        endcase
        nv = np ? 64'd0 : wd;
        live = we && wa != 0;
        e.a_data = (a == 0) ? 64'd0 : (live && wa == a) ? nv : m_val[a];
        e.a_p    = (a == 0) ? 1'b0  : (live && wa == a) ? np : m_p[a];
        e.b_data = (b == 0) ? 64'd0 : (live && wa == b) ? nv : m_val[b];
        e.b_p    = (b == 0) ? 1'b0  : (live && wa == b) ? np : m_p[b];
        e.rec    = ce && ((ca == 0) ? 1'b0 : (live && wa == ca) ? np : m_p[ca]);
        e.req    = req;
        q.push_back(e);
        if (live) begin
            m_val[wa] = nv;
            m_p[wa]   = np;
        end
    endtask

    // Monitor: compares at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (ra_data !== e.a_data || ra_poison !== e.a_p) begin
                bad++;
                $display("FAIL %s port A: got %h/%b exp %h/%b", e.req, ra_data, ra_poison, e.a_data, e.a_p);
            end
            total++;
            if (rb_data !== e.b_data || rb_poison !== e.b_p) begin
                bad++;
                $display("FAIL %s port B: got %h/%b exp %h/%b", e.req, rb_data, rb_poison, e.b_data, e.b_p);
            end
            total++;
            if (chk_recover !== e.rec) begin
                bad++;
                $display("FAIL %s check: got %b exp %b", e.req, chk_recover, e.rec);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset contents
        step(0, 2'b00, 0, 0, 0, 0, 6'd1, 6'd63, 1, 6'd17, "R1");
        step(0, 2'b00, 0, 0, 0, 0, 6'd40, 6'd2, 0, 6'd0, "R1");
        // R9: write r1 and read it in the same cycle on port A
        step(1, 2'b00, 6'd1, 64'hA5A5_0000_1234_5678, 0, 0, 6'd1, 6'd2, 0, 6'd0, "R9");
        // R2: value retained
        step(0, 2'b00, 0, 0, 0, 0, 6'd2, 6'd1, 0, 6'd0, "R2");
        // R5: move with poison, nonzero data stored as zero
        step(1, 2'b00, 6'd2, 64'hFFFF_FFFF_0000_0001, 1, 0, 6'd0, 6'd0, 0, 6'd0, "R5");
        step(0, 2'b00, 0, 0, 0, 0, 6'd2, 6'd2, 1, 6'd2, "R5");
        // R3: speculative load with fault, wr_poison ignored on clean one
        step(1, 2'b01, 6'd3, 64'h1111, 0, 1, 6'd0, 6'd0, 0, 6'd0, "R3");
        step(1, 2'b01, 6'd4, 64'h0000_0000_DEAD_BEEF, 1, 0, 6'd3, 6'd0, 0, 6'd0, "R3");
        step(0, 2'b00, 0, 0, 0, 0, 6'd3, 6'd4, 1, 6'd4, "R3");
        // R4: ALU from clean sources and from one poisoned source
        step(1, 2'b10, 6'd5, 64'h55, 1, 1, 6'd1, 6'd4, 0, 6'd0, "R4");
        step(1, 2'b10, 6'd6, 64'h66, 0, 0, 6'd1, 6'd3, 0, 6'd0, "R4");
        step(0, 2'b00, 0, 0, 0, 0, 6'd5, 6'd6, 1, 6'd5, "R4");
        // R7: chain r6 -> r7 -> r8, single check at the end
        step(1, 2'b10, 6'd7, 64'h77, 0, 0, 6'd6, 6'd1, 0, 6'd0, "R7");
        step(1, 2'b10, 6'd8, 64'h88, 0, 0, 6'd7, 6'd4, 0, 6'd0, "R7");
        step(0, 2'b00, 0, 0, 0, 0, 6'd8, 6'd7, 1, 6'd8, "R7");
        // R6: check disabled on a poisoned register
        step(0, 2'b00, 0, 0, 0, 0, 6'd6, 6'd5, 0, 6'd6, "R6");
        // R2: clean move clears poison of r3, also via reserved kind on r2
        step(1, 2'b00, 6'd3, 64'h3333, 0, 0, 6'd0, 6'd3, 1, 6'd3, "R2");
        step(1, 2'b11, 6'd2, 64'h2222, 0, 0, 6'd3, 6'd2, 1, 6'd2, "R2");
        // R8: writes to r0 ignored, check of r0 never recovers
        step(1, 2'b00, 6'd0, 64'hBAD, 1, 0, 6'd0, 6'd0, 1, 6'd0, "R8");
        step(0, 2'b00, 0, 0, 0, 0, 6'd0, 6'd0, 1, 6'd0, "R8");
        // R9: bypass on port B and on the check with a faulting load
        step(1, 2'b01, 6'd63, 64'h9, 0, 1, 6'd1, 6'd63, 1, 6'd63, "R9");
        step(0, 2'b00, 0, 0, 0, 0, 6'd63, 6'd1, 1, 6'd63, "R9");
        step(0, 2'b00, 0, 0, 0, 0, 6'd0, 6'd0, 0, 6'd0, "R9");
        repeat (3) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule